// File: doc/BRIEF.md
# Linked-List Summing Engine

This block walks a singly linked list stored in a 256-byte single-ported memory and adds up the signed byte values held in the list's nodes. Every node occupies two consecutive bytes: the link to the next node comes first and the node's value sits in the byte after it. The walk always begins at address 0, and a link of zero ends the list.

A host first loads the list through a byte write port while the engine is idle. It then pulses `start`. The engine follows the links and raises `done` when the walk is finished, with the wrapped sum on `result`. The loop is modulo-scheduled so that value fetches and link fetches for different nodes overlap. In steady state the engine reads memory once and adds once in every cycle, and it retires one node every two cycles.

Top module: `lsum_engine`

## Requirements
- R1: On a rising edge where `wrEn` is high and the engine is idle, the byte `wrData` is stored at `wrAddr`. The engine is idle before the first `start` and while `done` is high. A write presented while a walk is in progress is ignored and leaves the memory unchanged.
- R2: A node at address A holds its link at A and its value at A+1. The first node is at address 0. A link equal to 0 marks the last node.
- R3: `result` equals the sum, modulo 256, of the values of every node in the list, the last node included. No byte reached through the terminating zero link is added. A list with one node yields the byte at address 1. No overflow indication exists.
- R4: For a list of n nodes, `done` is first high after the 2n+1-th rising edge that follows the edge at which `start` was sampled high.
- R5: During a walk the engine makes at most one memory read and one addition per cycle. A value fetch is always followed by either a link fetch or the final addition.
- R6: `done` is low in the cycle after `start` is sampled and stays low until the walk completes. After that, `done` stays high and `result` holds its value until the next `start`.
- R7: A `start` sampled while a walk is in progress abandons that walk and restarts it from address 0. Both the timing of R4 and the value of R3 then apply from the new `start`.
- R8: While `rstN` is low, `done` and `result` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins or restarts a walk from address 0 |
| wrEn | input | 1 | Preload write enable, honoured only when idle |
| wrAddr | input | 8 | Preload write address |
| wrData | input | 8 | Preload write data |
| done | output | 1 | High once the walk has finished, until the next start |
| result | output | 8 | Wrapped sum of the list values |

## Verification
The finish of a walk of n nodes is due exactly 2n+1 rising edges after the edge at which `start` is sampled. The bench pulses `start` across one edge and then counts falling edges until `done` is seen, comparing the count with 2n+1 and reading `result` at that point. The low `done` is checked at the first falling edge after the start edge. Idle writes are checked one edge after they are presented, and ignored writes are checked by a second walk over the same list.

// File: rtl/lsum_pkg.sv
package lsum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_INIT      = 3'd1,
    ST_FETCH_VAL = 3'd2,
    ST_FETCH_LNK = 3'd3,
    ST_LAST_ADD  = 3'd4,
    ST_FINISHED  = 3'd5
  } lsum_state_e;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic initLoad;   // read head link, clear sum, point at first value
    logic fetchVal;   // read value at valAddr, advance valAddr to next+1
    logic fetchLink;  // read link at nextPtr, accumulate held value
    logic lastAdd;    // accumulate held value and publish result
  } lsum_strobe_t;

endpackage

// File: rtl/lsum_mem.sv
module lsum_mem #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         engineIdle,
  input  logic         wrEn,
  input  logic [W-1:0] wrAddr,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] rdAddr,
  output logic [W-1:0] rdData
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] store [DEPTH];
  logic         wrAccept;

  assign wrAccept = wrEn && engineIdle;

  always_ff @(posedge clk) begin
    if (wrAccept) store[wrAddr] <= wrData;
  end

  assign rdData = store[rdAddr];

endmodule

// File: rtl/lsum_ctrl.sv
module lsum_ctrl
  import lsum_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         nextZero,
  output lsum_strobe_t stb,
  output logic         engineIdle,
  output logic         done
);
  lsum_state_e state;
  lsum_state_e stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:      stateNxt = ST_IDLE;
      ST_FINISHED:  stateNxt = ST_FINISHED;
      ST_INIT:      stateNxt = ST_FETCH_VAL;
      ST_FETCH_VAL: stateNxt = nextZero ? ST_LAST_ADD : ST_FETCH_LNK;
      ST_FETCH_LNK: stateNxt = ST_FETCH_VAL;
      ST_LAST_ADD:  stateNxt = ST_FINISHED;
      default:      stateNxt = ST_IDLE;
    endcase
    if (start) stateNxt = ST_INIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stb           = '0;
    stb.initLoad  = (state == ST_INIT);
    stb.fetchVal  = (state == ST_FETCH_VAL);
    stb.fetchLink = (state == ST_FETCH_LNK);
    stb.lastAdd   = (state == ST_LAST_ADD);
  end

  assign engineIdle = (state == ST_IDLE) || (state == ST_FINISHED);
  assign done       = (state == ST_FINISHED);

  // R5
  val_then_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fetchVal && !start) |=> (stb.fetchLink || stb.lastAdd));

  // R5
  link_then_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fetchLink && !start) |=> stb.fetchVal);

endmodule

// File: rtl/lsum_datapath.sv
module lsum_datapath
  import lsum_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  lsum_strobe_t stb,
  input  logic [W-1:0] rdData,
  output logic [W-1:0] rdAddr,
  output logic         nextZero,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] HEAD_ADDR  = '0;
  localparam logic [W-1:0] FIRST_VAL  = W'(1);
  localparam logic [W-1:0] ONE        = W'(1);

  logic [W-1:0] nextPtr;
  logic [W-1:0] valAddr;
  logic [W-1:0] xHold;
  logic [W-1:0] sumAcc;
  logic [W-1:0] resultReg;
  logic [W-1:0] addA;
  logic [W-1:0] addB;
  logic [W-1:0] addOut;

  // Single read port: head, link or value address.
  always_comb begin
    if (stb.initLoad)       rdAddr = HEAD_ADDR;
    else if (stb.fetchLink) rdAddr = nextPtr;
    else                    rdAddr = valAddr;
  end

  // Single shared adder: pointer increment or accumulation.
  assign addA   = stb.fetchVal ? nextPtr : sumAcc;
  assign addB   = stb.fetchVal ? ONE     : xHold;
  assign addOut = addA + addB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPtr   <= '0;
      valAddr   <= '0;
      xHold     <= '0;
      sumAcc    <= '0;
      resultReg <= '0;
    end else begin
      if (stb.initLoad) begin
        nextPtr <= rdData;
        sumAcc  <= '0;
        valAddr <= FIRST_VAL;
        xHold   <= '0;
      end
      if (stb.fetchVal) begin
        xHold   <= rdData;
        valAddr <= addOut;
      end
      if (stb.fetchLink) begin
        nextPtr <= rdData;
        sumAcc  <= addOut;
      end
      if (stb.lastAdd) begin
        sumAcc    <= addOut;
        resultReg <= addOut;
      end
    end
  end

  assign nextZero = (nextPtr == '0);
  assign result   = resultReg;

  // R5
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.initLoad, stb.fetchVal, stb.fetchLink, stb.lastAdd}));

  // R3
  no_fetch_past_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fetchLink |-> (nextPtr != '0));

  // R3
  last_add_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.lastAdd |-> (nextPtr == '0));

  // R2
  init_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.initLoad |=> (sumAcc == '0 && valAddr == FIRST_VAL && xHold == '0));

endmodule

// File: rtl/lsum_engine.sv
module lsum_engine
  import lsum_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         wrEn,
  input  logic [W-1:0] wrAddr,
  input  logic [W-1:0] wrData,
  output logic         done,
  output logic [W-1:0] result
);
  lsum_strobe_t stb;
  logic         engineIdle;
  logic         nextZero;
  logic [W-1:0] rdAddr;
  logic [W-1:0] rdData;

  lsum_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .nextZero   (nextZero),
    .stb        (stb),
    .engineIdle (engineIdle),
    .done       (done)
  );

  lsum_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .nextZero (nextZero),
    .result   (result)
  );

  lsum_mem #(.W(W)) u_mem (
    .clk        (clk),
    .engineIdle (engineIdle),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .rdData     (rdData)
  );

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(result)));

  // R7
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

endmodule

// File: tb/lsum_engine_bench.sv
`timescale 1ns/1ps
module lsum_engine_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       done;
  logic [7:0] result;

  int testCount = 0;
  int failCount = 0;
  int nodeAddr [16];
  int expSum;

  always #5 clk = ~clk;

  lsum_engine u_lsum_engine (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .done(done), .result(result)
  );

  initial begin
    #1_500_000;
    failCount++;
    $display("FAIL watchdog R4: actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic writeByte(input int a, input int d);
    wrEn = 1'b1; wrAddr = 8'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic startPulse();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // R2: node k at nodeAddr[k], link first then value; head at 0.
  task automatic buildList(input int n, input int stride, input int dir, input int salt);
    int v;
    expSum = 0;
    for (int k = 0; k < n; k++)
      nodeAddr[k] = (k == 0) ? 0 : (dir != 0 ? 254 - 2*k*stride : 2*k*stride);
    for (int k = 0; k < n; k++) begin
      v = (k*73 + stride*29 + dir*101 + n*17 + salt) & 255;
      writeByte(nodeAddr[k], (k == n-1) ? 0 : nodeAddr[k+1]);
      writeByte(nodeAddr[k] + 1, v);
      expSum = (expSum + v) & 255;
    end
  endtask

  task automatic runAndCheck(input int n, input string tag);
    int cyc;
    startPulse();
    check(done == 1'b0, {"R6 done low after start ", tag}, int'(done), 0);
    waitDone(cyc);
    check(cyc == 2*n + 1, {"R4 R5 cycles to done ", tag}, cyc, 2*n + 1);
    check(int'(result) == expSum, {"R3 sum ", tag}, int'(result), expSum);
  endtask

  initial begin
    int cyc;
    int held;
    @(negedge clk);
    @(negedge clk);
    // R8
    check(done == 1'b0, "R8 done in reset", int'(done), 0);
    check(result == 8'd0, "R8 result in reset", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: single node list yields the byte at address 1.
    writeByte(0, 0);
    writeByte(1, 8'hB7);
    expSum = 8'hB7;
    runAndCheck(1, "single node");

    // R3: wrap modulo 256 with positive and negative values.
    writeByte(0, 40); writeByte(1, 8'h7F);
    writeByte(40, 60); writeByte(41, 8'h7F);
    writeByte(60, 0); writeByte(61, 8'h03);
    expSum = 8'h01;
    runAndCheck(3, "positive wrap");
    writeByte(0, 90); writeByte(1, 8'h80);
    writeByte(90, 0); writeByte(91, 8'h80);
    expSum = 8'h00;
    runAndCheck(2, "negative wrap");

    // Sweep: lengths 1..8, four strides, ascending and descending layouts.
    for (int n = 1; n <= 8; n++)
      for (int s = 1; s <= 7; s += 2)
        for (int d = 0; d < 2; d++) begin
          buildList(n, s, d, 0);
          runAndCheck(n, $sformatf("sweep n=%0d s=%0d d=%0d", n, s, d));
        end

    // R6: done and result hold while idle, even across idle writes.
    held = int'(result);
    for (int i = 0; i < 6; i++) writeByte(200 + i, i * 31);
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R6 done held", int'(done), 1);
    check(int'(result) == held, "R6 result held", int'(result), held);

    // R1: idle write changes the list; next walk sees it.
    buildList(5, 3, 0, 7);
    writeByte(nodeAddr[4] + 1, 8'h10);
    expSum = 0;
    for (int k = 0; k < 5; k++)
      expSum = (expSum + ((k == 4) ? 8'h10 : ((k*73 + 3*29 + 5*17 + 7) & 255))) & 255;
    runAndCheck(5, "R1 idle write applied");

    // R1: write while busy is ignored, both in this walk and the next.
    buildList(6, 5, 1, 3);
    startPulse();
    writeByte(nodeAddr[5] + 1, (expSum + 8'h5A) & 255);
    waitDone(cyc);
    check(int'(result) == expSum, "R1 busy write ignored", int'(result), expSum);
    runAndCheck(6, "R1 memory unchanged after busy write");

    // R7: restart mid-walk.
    buildList(7, 1, 0, 11);
    startPulse();
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R7 busy before restart", int'(done), 0);
    runAndCheck(7, "R7 restart");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule